// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It walks a two-level tree of descriptors held in memory. A requester hands over one translation at a time with a valid/ready handshake. The request carries the logical address, a flag that selects supervisor or user space, and a flag that marks the access as a write. The flag selects one of two root table bases. From there the walker reads a segment descriptor and then a page descriptor through a single-outstanding memory read port.

Each descriptor is one 32-bit word. Bits 31:12 hold a 20-bit base and bits 11:0 hold status. Bit 0 of the status is valid and bit 2 is write-protect. The two indices come from the logical address: bits 31:22 at the first level and bits 21:12 at the second. Each fetch address is the table base, then the index, then two zero bits. A successful walk returns the page base joined with logical bits 11:0, and passes the page status through.

A walk that meets any of the following stops at once and returns a 2-bit fault code:
- a bus error,
- an invalid descriptor,
- a write to a protected level.

Fault codes: 00 none, 01 invalid, 10 protection, 11 bus error. The result stays on the outputs until the next request is accepted.

Top module: `xlat_walker`

## Requirements
- R1: While rst_n is low, and after its release until a request is accepted, done and mem_req are 0 and req_ready is 1.
- R2: The first fetch of a walk reads address {root, laddr[31:22], 2'b00}. The root is super_root when req_super is 1 and user_root otherwise.
- R3: The second fetch reads address {segment descriptor[31:12], laddr[21:12], 2'b00}.
- R4: A walk that passes both levels ends with done=1 and rsp_fault=2'b00. It returns rsp_paddr={page descriptor[31:12], laddr[11:0]} and rsp_status = page descriptor[11:0].
- R5: A descriptor whose bit 0 is 0, at either level, ends the walk with rsp_fault=2'b01 and no further fetch.
- R6: A write meeting a descriptor whose bit 2 is 1, at either level, ends the walk with rsp_fault=2'b10. A read is not blocked by bit 2.
- R7: A response with mem_err=1 ends the walk with rsp_fault=2'b11 and no further fetch.
- R8: From acceptance until done, req_ready is 0 and new requests have no effect on the walk. mem_req stays high with a stable mem_addr until mem_gnt.
- R9: done and the result hold until the next request is accepted. A request presented while done is high is accepted and starts a new walk one cycle later.
- R10: At one level, a bus error outranks invalid, and invalid outranks write-protect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_root | input | 20 | Root table base for user accesses |
| super_root | input | 20 | Root table base for supervisor accesses |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_laddr | input | 32 | Logical address to translate |
| req_super | input | 1 | 1 = supervisor space, 0 = user space |
| req_write | input | 1 | 1 = write access, 0 = read |
| done | output | 1 | Result valid, held until next accept |
| rsp_fault | output | 2 | 00 none, 01 invalid, 10 protection, 11 bus error |
| rsp_paddr | output | 32 | Physical address (valid when rsp_fault is 00) |
| rsp_status | output | 12 | Status bits of the last descriptor read |
| mem_req | output | 1 | Descriptor read request |
| mem_gnt | input | 1 | Read request accepted by memory |
| mem_addr | output | 32 | Word-aligned descriptor address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Descriptor word |
| mem_err | input | 1 | Read response carries a bus error |

## Verification
Three outcomes are hard to reach from the ports. They are:
- a write refused by the segment level while the page level would allow it,
- a descriptor that is both invalid and write-protected,
- a bus error on the second fetch rather than the first.

The bench reaches each of them with a memory model of sparse descriptor contents. That model also has two fault-injecting addresses, one in a segment table and one in a page table. The model withholds grants for a varied number of cycles, so the request-hold behaviour is exercised. A separate test keeps a second request asserted for the whole of a walk. It shows that the result and the fetch count belong only to the first request.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int LA_W   = 32;
  localparam int BASE_W = 20;
  localparam int IDX_W  = 10;
  localparam int STAT_W = 12;
  localparam int LEVELS = 2;
  localparam int OFF_W  = LA_W - LEVELS * IDX_W;
  localparam int PA_W   = BASE_W + OFF_W;
  localparam int MA_W   = BASE_W + IDX_W + 2;
  localparam int IXS_W  = LEVELS * IDX_W;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_INVALID = 2'b01,
    FLT_PROT    = 2'b10,
    FLT_BUS     = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [STAT_W-1:0] stat;
  } desc_t;
endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen
  import xlat_pkg::*;
(
  input  logic [IXS_W-1:0]  idx_field,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [BASE_W-1:0] tbl_base,
  output logic [MA_W-1:0]   fetch_addr
);
  logic [IDX_W-1:0] idx_lvl [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  // level 0 uses the most significant index field
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_lvl[g] = idx_field[IXS_W-1-g*IDX_W -: IDX_W];
  end

  always_comb begin
    idx_sel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i)) idx_sel = idx_lvl[i];
    end
  end

  assign fetch_addr = {tbl_base, idx_sel, 2'b00};
endmodule

// File: rtl/xlat_desc_check.sv
module xlat_desc_check
  import xlat_pkg::*;
(
  input  logic   bus_err,
  input  logic   valid_bit,
  input  logic   wp_bit,
  input  logic   is_write,
  output fault_e fault
);
  // priority: bus error, then invalid, then write protection (R10)
  always_comb begin
    if (bus_err)                fault = FLT_BUS;
    else if (!valid_bit)        fault = FLT_INVALID;
    else if (is_write && wp_bit) fault = FLT_PROT;
    else                        fault = FLT_NONE;
  end
endmodule

// File: rtl/xlat_walk_fsm.sv
module xlat_walk_fsm
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   req_laddr,
  input  logic              req_super,
  input  logic              req_write,
  input  logic [BASE_W-1:0] user_root,
  input  logic [BASE_W-1:0] super_root,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  desc_t             rdesc,
  input  fault_e            chk_fault,
  output walk_st_e          state,
  output logic [LVL_W-1:0]  lvl,
  output logic [BASE_W-1:0] tbl_base,
  output logic [IXS_W-1:0]  la_idx,
  output logic              is_write,
  output logic [PA_W-1:0]   res_paddr,
  output fault_e            res_fault,
  output logic [STAT_W-1:0] res_status
);
  walk_st_e          state_q, state_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [LA_W-1:0]   la_q;
  logic              wr_q;
  logic [PA_W-1:0]   paddr_q, paddr_d;
  fault_e            fault_q, fault_d;
  logic [STAT_W-1:0] stat_q, stat_d;

  logic accept, resp, last, descend, finish;

  assign accept  = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && req_valid;
  assign resp    = (state_q == ST_WAIT) && mem_rvalid;
  assign last    = (lvl_q == LVL_W'(LEVELS - 1));
  assign descend = resp && (chk_fault == FLT_NONE) && !last;
  assign finish  = resp && ((chk_fault != FLT_NONE) || last);

  // next-state process
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    paddr_d = paddr_q;
    fault_d = fault_q;
    stat_d  = stat_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          state_d = ST_FETCH;
          lvl_d   = '0;
          base_d  = req_super ? super_root : user_root;
        end
      end
      ST_FETCH: begin
        if (mem_gnt) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (descend) begin
          state_d = ST_FETCH;
          lvl_d   = lvl_q + LVL_W'(1);
          base_d  = rdesc.base;
        end else if (finish) begin
          state_d = ST_DONE;
          fault_d = chk_fault;
          stat_d  = rdesc.stat;
          paddr_d = (chk_fault == FLT_NONE) ? {rdesc.base, la_q[OFF_W-1:0]} : '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      la_q    <= '0;
      wr_q    <= 1'b0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
      stat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        la_q <= req_laddr;
        wr_q <= req_write;
      end
      if (accept || descend) begin
        lvl_q  <= lvl_d;
        base_q <= base_d;
      end
      if (finish) begin
        paddr_q <= paddr_d;
        fault_q <= fault_d;
        stat_q  <= stat_d;
      end
    end
  end

  assign state      = state_q;
  assign lvl        = lvl_q;
  assign tbl_base   = base_q;
  assign la_idx     = la_q[LA_W-1 -: IXS_W];
  assign is_write   = wr_q;
  assign res_paddr  = paddr_q;
  assign res_fault  = fault_q;
  assign res_status = stat_q;

  // R6: a protection fault is reported only for a write
  p_prot_only_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && fault_q == FLT_PROT) |-> wr_q);

  // R3: a clean non-final level moves to the next level's fetch
  p_descend_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && mem_rvalid && chk_fault == FLT_NONE && !last)
    |=> (state_q == ST_FETCH && lvl_q == $past(lvl_q) + LVL_W'(1)));

  // R4: a clean final level completes the walk
  p_last_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && mem_rvalid && chk_fault == FLT_NONE && last)
    |=> (state_q == ST_DONE && fault_q == FLT_NONE));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VALID_BIT = 0,
  parameter int WP_BIT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] user_root,
  input  logic [BASE_W-1:0] super_root,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_laddr,
  input  logic              req_super,
  input  logic              req_write,
  output logic              done,
  output logic [1:0]        rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [STAT_W-1:0] rsp_status,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [MA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [LA_W-1:0]   mem_rdata,
  input  logic              mem_err
);
  walk_st_e          state;
  logic [LVL_W-1:0]  lvl;
  logic [BASE_W-1:0] tbl_base;
  logic [IXS_W-1:0]  la_idx;
  logic              is_write;
  desc_t             rdesc;
  fault_e            chk_fault;
  fault_e            res_fault;

  assign rdesc = desc_t'(mem_rdata);

  xlat_walk_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_laddr  (req_laddr),
    .req_super  (req_super),
    .req_write  (req_write),
    .user_root  (user_root),
    .super_root (super_root),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .rdesc      (rdesc),
    .chk_fault  (chk_fault),
    .state      (state),
    .lvl        (lvl),
    .tbl_base   (tbl_base),
    .la_idx     (la_idx),
    .is_write   (is_write),
    .res_paddr  (rsp_paddr),
    .res_fault  (res_fault),
    .res_status (rsp_status)
  );

  xlat_addr_gen u_addr (
    .idx_field  (la_idx),
    .lvl        (lvl),
    .tbl_base   (tbl_base),
    .fetch_addr (mem_addr)
  );

  xlat_desc_check u_chk (
    .bus_err   (mem_err),
    .valid_bit (rdesc.stat[VALID_BIT]),
    .wp_bit    (rdesc.stat[WP_BIT]),
    .is_write  (is_write),
    .fault     (chk_fault)
  );

  assign req_ready = (state == ST_IDLE) || (state == ST_DONE);
  assign mem_req   = (state == ST_FETCH);
  assign done      = (state == ST_DONE);
  assign rsp_fault = res_fault;

  // R8: no new request is taken while a fetch is being requested
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R8: an ungranted fetch request holds with a stable address
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  // R7: a bus-error response aborts the walk with the bus fault code
  p_bus_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && mem_err && !req_ready && !mem_req)
    |=> (done && rsp_fault == 2'b11));

  // R9: result holds while no new request arrives
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_valid) |=> (done && $stable(rsp_paddr) && $stable(rsp_fault)));
endmodule

// File: tb/xlat_walker_tb_top.sv
`timescale 1ns/1ps
module xlat_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] user_root, super_root;
  logic        req_valid, req_ready, req_super, req_write;
  logic [31:0] req_laddr;
  logic        done;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_paddr;
  logic [11:0] rsp_status;
  logic        mem_req, mem_gnt, mem_rvalid, mem_err;
  logic [31:0] mem_addr, mem_rdata;

  always #2.5 clk = ~clk;

  xlat_walker dut_i (
    .clk(clk), .rst_n(rst_n), .user_root(user_root), .super_root(super_root),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .req_super(req_super), .req_write(req_write), .done(done),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  localparam logic [19:0] UR = 20'h10000;
  localparam logic [19:0] SR = 20'h20000;

  typedef struct packed {
    logic        sup;
    logic        wr;
    logic [9:0]  seg;
    logic [9:0]  pg;
    logic [11:0] off;
    logic [1:0]  gdly;
    logic [1:0]  efault;
    logic [19:0] ebase;
    logic [11:0] estat;
    logic [1:0]  nfetch;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 10'h001, 10'h005, 12'h123, 2'd0, 2'd0, 20'hABCDE, 12'h001, 2'd2},
    '{1'b0, 1'b1, 10'h001, 10'h005, 12'hFFF, 2'd1, 2'd0, 20'hABCDE, 12'h001, 2'd2},
    '{1'b0, 1'b0, 10'h001, 10'h006, 12'h000, 2'd2, 2'd0, 20'h12345, 12'h005, 2'd2},
    '{1'b0, 1'b1, 10'h001, 10'h006, 12'h010, 2'd0, 2'd2, 20'h00000, 12'h000, 2'd2},
    '{1'b0, 1'b0, 10'h001, 10'h007, 12'h456, 2'd3, 2'd1, 20'h00000, 12'h000, 2'd2},
    '{1'b0, 1'b0, 10'h002, 10'h000, 12'hFFF, 2'd0, 2'd0, 20'h55555, 12'h0C1, 2'd2},
    '{1'b0, 1'b1, 10'h002, 10'h000, 12'h001, 2'd1, 2'd2, 20'h00000, 12'h000, 2'd1},
    '{1'b0, 1'b0, 10'h003, 10'h00A, 12'h000, 2'd0, 2'd1, 20'h00000, 12'h000, 2'd1},
    '{1'b1, 1'b0, 10'h001, 10'h005, 12'h123, 2'd0, 2'd0, 20'h77777, 12'h081, 2'd2},
    '{1'b0, 1'b0, 10'h004, 10'h000, 12'h000, 2'd2, 2'd3, 20'h00000, 12'h000, 2'd1},
    '{1'b0, 1'b1, 10'h001, 10'h008, 12'h000, 2'd0, 2'd3, 20'h00000, 12'h000, 2'd2},
    '{1'b1, 1'b1, 10'h003, 10'h000, 12'h000, 2'd0, 2'd1, 20'h00000, 12'h000, 2'd1},
    '{1'b0, 1'b1, 10'h005, 10'h000, 12'h000, 2'd0, 2'd1, 20'h00000, 12'h000, 2'd1},
    '{1'b1, 1'b1, 10'h001, 10'h005, 12'h800, 2'd1, 2'd0, 20'h77777, 12'h081, 2'd2}
  };

  // memory model
  logic [31:0] mem   [logic [31:0]];
  bit          errmap[logic [31:0]];
  logic [31:0] log_addr [2];
  int          nf, gdly_tb, gcnt;
  bit          pend;
  logic [31:0] pend_addr;

  int n_cmp = 0;
  int n_bad = 0;

  initial begin
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    pend = 1'b0; gcnt = 0; nf = 0; gdly_tb = 0; pend_addr = '0;
    forever begin
      @(negedge clk);
      mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_err = 1'b0;
      if (pend) begin
        mem_rvalid = 1'b1;
        mem_err    = errmap.exists(pend_addr);
        mem_rdata  = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
        pend = 1'b0;
      end else if (mem_req) begin
        if (gcnt >= gdly_tb) begin
          mem_gnt = 1'b1;
          pend_addr = mem_addr;
          if (nf < 2) log_addr[nf] = mem_addr;
          nf++;
          pend = 1'b1;
          gcnt = 0;
        end else gcnt++;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int i, input logic [1:0] f);
    if (i == 9 || i == 12) return "R10";
    case (f)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic issue(input logic sup, input logic wr, input logic [31:0] la);
    nf = 0;
    @(negedge clk);
    req_valid = 1'b1; req_super = sup; req_write = wr; req_laddr = la;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "req_ready after accept", {31'b0, req_ready}, 32'h0);
    chk("R9", "done drops after accept", {31'b0, done}, 32'h0);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held_pa;
    logic [1:0]  held_f;
    user_root = UR; super_root = SR;
    req_valid = 1'b0; req_super = 1'b0; req_write = 1'b0; req_laddr = '0;
    rst_n = 1'b0;

    mem[{UR, 10'h001, 2'b00}]      = {20'h30000, 12'h001};
    mem[{20'h30000, 10'h005, 2'b00}] = {20'hABCDE, 12'h001};
    mem[{20'h30000, 10'h006, 2'b00}] = {20'h12345, 12'h005};
    mem[{20'h30000, 10'h007, 2'b00}] = {20'h99999, 12'h004};
    mem[{UR, 10'h002, 2'b00}]      = {20'h31000, 12'h005};
    mem[{20'h31000, 10'h000, 2'b00}] = {20'h55555, 12'h0C1};
    mem[{UR, 10'h003, 2'b00}]      = {20'h32000, 12'h000};
    mem[{UR, 10'h005, 2'b00}]      = {20'h33000, 12'h004};
    mem[{SR, 10'h001, 2'b00}]      = {20'h40000, 12'h001};
    mem[{20'h40000, 10'h005, 2'b00}] = {20'h77777, 12'h081};
    errmap[{UR, 10'h004, 2'b00}]       = 1'b1;
    errmap[{20'h30000, 10'h008, 2'b00}] = 1'b1;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", {31'b0, done}, 32'h0);
    chk("R1", "mem_req in reset", {31'b0, mem_req}, 32'h0);
    chk("R1", "req_ready in reset", {31'b0, req_ready}, 32'h1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "done after release", {31'b0, done}, 32'h0);
    chk("R1", "mem_req after release", {31'b0, mem_req}, 32'h0);

    // table-driven walks
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] la, a1, a2;
      string t;
      v = VECS[i];
      la = {v.seg, v.pg, v.off};
      gdly_tb = int'(v.gdly);
      issue(v.sup, v.wr, la);
      wait_done();
      t = tag_of(i, v.efault);
      chk(t, "done", {31'b0, done}, 32'h1);
      chk(t, "fault", {30'b0, rsp_fault}, {30'b0, v.efault});
      chk((v.efault == 2'd1) ? "R5" : (v.efault == 2'd3) ? "R7" : t,
          "fetch count", nf, {30'b0, v.nfetch});
      a1 = {(v.sup ? SR : UR), v.seg, 2'b00};
      chk("R2", "first fetch addr", log_addr[0], a1);
      if (v.nfetch == 2'd2) begin
        a2 = {mem[a1][31:12], v.pg, 2'b00};
        chk("R3", "second fetch addr", log_addr[1], a2);
      end
      if (v.efault == 2'd0) begin
        chk("R4", "paddr", rsp_paddr, {v.ebase, v.off});
        chk("R4", "status", {20'b0, rsp_status}, {20'b0, v.estat});
      end
    end

    // R9: result held while idle, then a new request taken from done
    gdly_tb = 0;
    issue(1'b0, 1'b0, {10'h001, 10'h005, 12'h0AB});
    wait_done();
    held_pa = rsp_paddr; held_f = rsp_fault;
    repeat (4) @(negedge clk);
    chk("R9", "done held", {31'b0, done}, 32'h1);
    chk("R9", "paddr held", rsp_paddr, held_pa);
    chk("R9", "fault held", {30'b0, rsp_fault}, {30'b0, held_f});
    chk("R9", "ready in done", {31'b0, req_ready}, 32'h1);
    issue(1'b0, 1'b0, {10'h001, 10'h006, 12'h321});
    wait_done();
    chk("R9", "second walk paddr", rsp_paddr, {20'h12345, 12'h321});

    // R8: competing request held high across a slow walk has no effect
    gdly_tb = 3; nf = 0;
    @(negedge clk);
    req_valid = 1'b1; req_super = 1'b0; req_write = 1'b0;
    req_laddr = {10'h001, 10'h005, 12'h777};
    @(posedge clk);
    @(negedge clk);
    req_laddr = {10'h002, 10'h000, 12'h111};
    req_write = 1'b1;
    chk("R8", "mem_req while waiting grant", {31'b0, mem_req}, 32'h1);
    @(negedge clk);
    chk("R8", "mem_req still held", {31'b0, mem_req}, 32'h1);
    chk("R8", "fetch addr while held", mem_addr, {UR, 10'h001, 2'b00});
    chk("R8", "ready during walk", {31'b0, req_ready}, 32'h0);
    wait_done();
    req_valid = 1'b0;
    chk("R8", "paddr of first request", rsp_paddr, {20'hABCDE, 12'h777});
    chk("R8", "fault of first request", {30'b0, rsp_fault}, 32'h0);
    chk("R8", "fetches of first request", nf, 32'd2);

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule